// File: doc/BRIEF.md
# Execute Packet Dispatcher

The dispatcher accepts a fetch packet of eight 32-bit instruction slots and issues it as a sequence of execute packets, one per clock. Bit 0 of each instruction is a chaining bit: a 1 links the following slot into the same execute packet, and a 0 closes the packet so that the next slot opens a new one. Slot 0 sits in bits [31:0] and is the earliest instruction. The slots are walked in increasing order.

Each dispatch cycle presents a slot mask, with one valid bit for each slot that belongs to the current execute packet, together with the instruction words in their own slot positions. The fetch side uses a valid/ready handshake. A new fetch packet is taken only when the held packet has no slots left to issue, or in the same cycle that its final execute packet leaves without a stall. The dispatch side uses a stall input. While stall is high, the presented packet is frozen.

Top module: `exec_pkt_dispatch`

## Requirements
- R1: After reset no fetch packet is held, `fp_ready` is 1 and `ep_valid` is all zeros.
- R2: A fetch packet is taken at a clock edge where `fp_valid` and `fp_ready` are both 1. In the next cycle the first execute packet is presented, starting at slot 0.
- R3: An execute packet starts at the lowest slot not yet dispatched. It extends through each following slot up to and including the first slot whose bit 0 is 0. `ep_valid[i]` is 1 exactly for its slots.
- R4: Bit 0 of slot 7 is treated as 0 whatever its value, so the last execute packet always ends at slot 7.
- R5: In each cycle with a packet presented and `ep_stall` low, that packet is consumed. The next cycle presents the following execute packet, or nothing if the fetch packet is used up and no new one was taken.
- R6: While `ep_stall` is 1, `ep_valid`, `ep_instr` and all internal progress stay unchanged.
- R7: `fp_ready` is 1 in two cases only: when no slots remain to dispatch, or when the presented packet is the last one of its fetch packet and `ep_stall` is 0. A fetch packet offered while `fp_ready` is 0 is ignored.
- R8: `ep_instr[32*i +: 32]` carries the word of slot i when `ep_valid[i]` is 1, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_valid | input | 1 | Fetch packet offered |
| fp_data | input | 256 | Fetch packet, slot i in bits [32*i+31:32*i] |
| fp_ready | output | 1 | Fetch packet can be taken this cycle |
| ep_valid | output | 8 | Slot mask of the presented execute packet |
| ep_instr | output | 256 | Instruction words of the presented packet, zero in unused slots |
| ep_stall | input | 1 | Downstream stall; holds the presented packet |

## Verification
Fetch packets are generated in four chaining patterns, each with different random words:
- Every chaining bit clear yields eight single-slot packets and checks the per-cycle walk.
- Every bit set, including slot 7, yields one eight-slot packet and separates a correct slot-7 cutoff from a packet that runs over.
- Alternating bits exercise two-slot packets.
- Random bits mix lengths at every start offset.

Random stalls and gaps in fetch valid show whether the presented packet freezes under a stall, and whether `fp_ready` rises in the final unstalled cycle and not in any earlier one.

// File: rtl/exec_pkt_dispatch.sv
module exec_pkt_dispatch #(
  parameter int SLOTS = 8,
  parameter int IW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fp_valid,
  input  logic [SLOTS*IW-1:0] fp_data,
  output logic                fp_ready,
  output logic [SLOTS-1:0]    ep_valid,
  output logic [SLOTS*IW-1:0] ep_instr,
  input  logic                ep_stall
);
  localparam int FW = SLOTS * IW;

  logic [FW-1:0]    fp_q;
  logic [SLOTS-1:0] pend_q;
  logic [SLOTS-1:0] pkt;
  logic [SLOTS-2:0] link;
  logic             busy, last, take, step;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i == 0) begin : g_first
      assign pkt[i] = pend_q[i];
    end else begin : g_next
      assign pkt[i] = pend_q[i] & (~pend_q[i-1] | (pkt[i-1] & link[i-1]));
    end
    if (i < SLOTS - 1) begin : g_link
      assign link[i] = fp_q[i*IW];
    end
    assign ep_instr[i*IW +: IW] = fp_q[i*IW +: IW] & {IW{pkt[i]}};
  end

  assign busy     = |pend_q;
  assign last     = ~|(pend_q & ~pkt);
  assign step     = busy & ~ep_stall;
  assign fp_ready = ~busy | (last & ~ep_stall);
  assign take     = fp_valid & fp_ready;
  assign ep_valid = pkt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      fp_q   <= '0;
    end else if (take) begin
      pend_q <= '1;
      fp_q   <= fp_data;
    end else if (step) begin
      pend_q <= pend_q & ~pkt;
    end
  end
endmodule

// File: rtl/exec_pkt_dispatch_chk.sv
module exec_pkt_dispatch_chk #(
  parameter int SLOTS = 8,
  parameter int IW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fp_valid,
  input logic                fp_ready,
  input logic [SLOTS-1:0]    ep_valid,
  input logic [SLOTS*IW-1:0] ep_instr,
  input logic                ep_stall
);
  logic [SLOTS-1:0] lowbit;
  assign lowbit = ep_valid & (~ep_valid + 1'b1);

  assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_valid == '0) |-> fp_ready);

  assert_take_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_valid && fp_ready) |=> ep_valid[0]);

  assert_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ep_valid + lowbit) & ep_valid) == '0);

  assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_valid != '0 && !ep_stall && !fp_ready) |=> ((ep_valid & $past(ep_valid)) == '0 && ep_valid != '0));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_valid != '0 && ep_stall) |=> ($stable(ep_valid) && $stable(ep_instr)));

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      if (rst_n && !ep_valid[i])
        assert_idle_slot_zero_R8: assert (ep_instr[i*IW +: IW] == '0);
    end
  end
endmodule

bind exec_pkt_dispatch exec_pkt_dispatch_chk #(.SLOTS(SLOTS), .IW(IW)) chk_i (.*);

// File: tb/exec_pkt_dispatch_tb_top.sv
module exec_pkt_dispatch_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fp_valid = 1'b0;
  logic [255:0] fp_data = '0;
  logic         fp_ready;
  logic [7:0]   ep_valid;
  logic [255:0] ep_instr;
  logic         ep_stall = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exec_pkt_dispatch dut_i (.*);

  logic [31:0] m_word [8];
  int          m_pos = 8;

  function automatic logic [31:0] gen_word(int kind, int s);
    logic [31:0] w;
    w = $urandom;
    case (kind)
      0: w[0] = 1'b0;
      1: w[0] = 1'b1;
      2: w[0] = s[0];
      default: ;
    endcase
    return w;
  endfunction

  task automatic check(string tag, string what, logic [255:0] act, logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int e;
    logic [7:0]   x_mask;
    logic [255:0] x_instr;
    logic         x_ready;
    logic         prev_stall;
    string        tag;
    prev_stall = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "fp_ready", {255'b0, fp_ready}, 256'd1);
    check("R1", "ep_valid", {248'b0, ep_valid}, 256'd0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int kind;
      kind = (cyc / 250) % 4;
      @(negedge clk);
      fp_valid = (($urandom % 4) != 0);
      for (int s = 0; s < 8; s++) fp_data[s*32 +: 32] = gen_word(kind, s);
      ep_stall = (cyc >= 1000 && cyc < 3000) ? (($urandom % 3) == 0) : 1'b0;
      if (cyc >= 3500 && cyc < 3520) begin
        fp_valid = 1'b1;
        ep_stall = 1'b1;
      end
      #1;
      x_mask = '0;
      x_instr = '0;
      e = 7;
      if (m_pos < 8) begin
        e = m_pos;
        while (e < 7 && m_word[e][0]) e++;
        for (int s = m_pos; s <= e; s++) begin
          x_mask[s] = 1'b1;
          x_instr[s*32 +: 32] = m_word[s];
        end
      end
      x_ready = (m_pos == 8) || (e == 7 && !ep_stall);
      if (prev_stall && m_pos < 8) tag = "R6";
      else if (x_mask[7]) tag = "R4";
      else if (m_pos == 0) tag = "R2";
      else if (m_pos < 8) tag = "R3";
      else tag = "R5";
      check(tag, "ep_valid", {248'b0, ep_valid}, {248'b0, x_mask});
      check("R8", "ep_instr", ep_instr, x_instr);
      check("R7", "fp_ready", {255'b0, fp_ready}, {255'b0, x_ready});
      if (fp_valid && x_ready) begin
        for (int s = 0; s < 8; s++) m_word[s] = fp_data[s*32 +: 32];
        m_pos = 0;
      end else if (m_pos < 8 && !ep_stall) begin
        m_pos = e + 1;
      end
      prev_stall = ep_stall;
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule